// File: doc/BRIEF.md
# Wide-Range Bit-Rate Acquisition and NCO Tracking

This block recovers the bit timing of a self-clocked serial line whose rate is not known in advance. The usable range spans about ten to one, from 10 to 100 system clocks per bit. When it comes out of reset, or after it loses lock, the block times the intervals between line edges during the preamble. The preamble is assumed to carry one transition per bit cell. The shortest interval seen in that run becomes the bit period estimate. A sequential divider turns this period into the starting increment of a phase-accumulator oscillator, so the loop needs no frequency search.

The loop then enters tracking. The first edge realigns the oscillator phase. After that, each line edge samples the phase, and the signed result is the phase error. A proportional-plus-integral filter with small gains, set by shift amounts, trims the increment, which keeps the recovered clock quiet. The lock flag rises after a run of edges with small error. If several edges in a row show a large error, the block drops lock and measures the rate again. Losing the first bits of a frame is accepted.

Downstream logic uses `tick_o` as its bit clock enable. It can use `period_o` as a window length whenever `period_vld_o` is high.

Top module: `rate_acq_top`

## Requirements
- R1: After reset, `tick_o`, `locked_o` and `period_vld_o` are 0 and `period_o` is 0.
- R2: After the first edge, the block times `meas_edges_i` edge-to-edge intervals in system clocks (a value of 0 counts as 1). `period_o` takes the smallest of these intervals and `period_vld_o` rises. `period_o` then holds while `period_vld_o` stays high.
- R3: An interval shorter than 2 clocks counts as 2 clocks, so `period_o` is never below 2 while valid.
- R4: The seed increment of the 2^ACC_W phase accumulator is floor(2^ACC_W / period), computed by a bit-serial divider. With a steady line, the block emits one tick per bit period: between 31 and 33 ticks over 32 periods.
- R5: `tick_o` is a single-cycle pulse and is never high on two cycles in a row.
- R6: The first edge in tracking snaps the phase. After that, `locked_o` rises once LOCK_EDGES consecutive edges show a phase error below 1/8 of a bit. On a steady preamble, lock is reached within 40 edges.
- R7: When UNLOCK_EDGES consecutive edges show a phase error above 1/4 of a bit, `locked_o` falls and `period_vld_o` falls. Measurement then restarts, and the block re-acquires lock and reports the period again.
- R8: `locked_o` is high only while tracking with a valid period.
- R9: At a constant rate, lock is held through a long run of bits, because the narrow loop does not disturb it.
- R10: With the same parameters, the block acquires and locks at both 10 and 100 clocks per bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | 1 | Serial line, already synchronous to clk_i |
| meas_edges_i | input | EDG_W | Number of intervals timed per measurement |
| tick_o | output | 1 | One-cycle pulse per recovered bit |
| locked_o | output | 1 | Tracking loop is locked |
| period_vld_o | output | 1 | `period_o` holds a valid measurement |
| period_o | output | CNT_W | Measured bit period in system clocks |

## Verification
The edge that closes the last timed interval sets `period_o` at its own clock edge, and `period_vld_o` follows one cycle later. The increment is ready ACC_W+1 cycles after that. `locked_o` and `tick_o` change at the clock edge where a line edge or a phase carry is registered. The bench toggles the line on falling clock edges and samples on falling edges. It reads the period only after more than ACC_W+1 idle cycles, and it checks lock and tick counts only after whole runs of bit periods. Because of this, no check depends on the exact cycle at which the loop settles.

// File: rtl/rate_acq_pkg.sv
package rate_acq_pkg;
  typedef enum logic [1:0] {
    ST_MEAS  = 2'd0,
    ST_DIV   = 2'd1,
    ST_TRACK = 2'd2
  } acq_st_e;
endpackage

// File: rtl/rate_acq_meas.sv
module rate_acq_meas #(
  parameter int CNT_W = 12,
  parameter int EDG_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             edge_i,
  input  logic [EDG_W-1:0] meas_edges_i,
  output logic             done_o,
  output logic [CNT_W-1:0] period_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] MIN_P   = CNT_W'(2);

  logic [CNT_W-1:0] cnt_q, min_q, cur, min_nx;
  logic [EDG_W-1:0] n_q, tgt;
  logic             seen_q;

  assign tgt    = (meas_edges_i == '0) ? EDG_W'(1) : meas_edges_i;
  assign cur    = (cnt_q < MIN_P) ? MIN_P : cnt_q;
  assign min_nx = (cur < min_q) ? cur : min_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      min_q    <= CNT_MAX;
      n_q      <= '0;
      seen_q   <= 1'b0;
      done_o   <= 1'b0;
      period_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (!en_i) begin
        cnt_q  <= '0;
        min_q  <= CNT_MAX;
        n_q    <= '0;
        seen_q <= 1'b0;
      end else if (edge_i) begin
        cnt_q  <= CNT_W'(1);
        seen_q <= 1'b1;
        if (seen_q) begin
          min_q <= min_nx;
          n_q   <= n_q + 1'b1;
          if (n_q + EDG_W'(1) >= tgt) begin
            done_o   <= 1'b1;
            period_o <= min_nx;
          end
        end
      end else if (cnt_q != CNT_MAX) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  AST_MEAS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !done_o); // R2
endmodule

// File: rtl/rate_acq_div.sv
module rate_acq_div #(
  parameter int ACC_W = 24,
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] divisor_i,
  output logic             done_o,
  output logic [ACC_W-1:0] quot_o
);
  localparam int SCW = $clog2(ACC_W + 1);

  logic [CNT_W-1:0] dvs_q, rem_q;
  logic [CNT_W:0]   rsh, rdiff;
  logic [ACC_W:0]   q_q;
  logic [SCW-1:0]   step_q;
  logic             busy_q, ge;

  // dividend is 2^ACC_W: a single one in the first step
  assign rsh   = {rem_q, (step_q == SCW'(ACC_W))};
  assign ge    = rsh >= {1'b0, dvs_q};
  assign rdiff = rsh - {1'b0, dvs_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dvs_q  <= '0;
      rem_q  <= '0;
      q_q    <= '0;
      step_q <= '0;
      busy_q <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        dvs_q  <= divisor_i;
        rem_q  <= '0;
        q_q    <= '0;
        step_q <= SCW'(ACC_W);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        rem_q  <= ge ? rdiff[CNT_W-1:0] : rsh[CNT_W-1:0];
        q_q    <= {q_q[ACC_W-1:0], ge};
        step_q <= step_q - 1'b1;
        if (step_q == '0) begin
          busy_q <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end

  assign quot_o = q_q[ACC_W-1:0];

  AST_QUOT_FITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !q_q[ACC_W]); // R4
  AST_DIV_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_q); // R4
endmodule

// File: rtl/rate_acq_track.sv
module rate_acq_track #(
  parameter int ACC_W        = 24,
  parameter int KP_SH        = 10,
  parameter int KI_SH        = 14,
  parameter int LOCK_SH      = 3,
  parameter int UNLOCK_SH    = 2,
  parameter int LOCK_EDGES   = 8,
  parameter int UNLOCK_EDGES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             load_i,
  input  logic [ACC_W-1:0] seed_i,
  input  logic             edge_i,
  output logic             tick_o,
  output logic             locked_o,
  output logic             lost_o
);
  localparam int SW = ACC_W + 2;
  localparam int LW = $clog2(LOCK_EDGES + 1);
  localparam int UW = $clog2(UNLOCK_EDGES + 1);
  localparam logic [ACC_W-1:0] LOCK_WIN   = ACC_W'(1) << (ACC_W - LOCK_SH);
  localparam logic [ACC_W-1:0] UNLOCK_WIN = ACC_W'(1) << (ACC_W - UNLOCK_SH);

  logic [ACC_W-1:0]     ph_q, seed_q, inc_u, abs_err;
  logic signed [SW-1:0] integ_q, prop_q, inc_s, err_s;
  logic [ACC_W:0]       sum;
  logic [LW-1:0]        good_q;
  logic [UW-1:0]        bad_q;
  logic                 aligned_q, err_in, err_out;

  assign inc_s   = $signed({2'b00, seed_q}) + integ_q + prop_q;
  assign inc_u   = inc_s[ACC_W-1:0];
  assign sum     = {1'b0, ph_q} + {1'b0, inc_u};
  // phase at the edge, read as signed: positive = oscillator early
  assign err_s   = $signed({{2{ph_q[ACC_W-1]}}, ph_q});
  assign abs_err = ph_q[ACC_W-1] ? (~ph_q + 1'b1) : ph_q;
  assign err_in  = abs_err < LOCK_WIN;
  assign err_out = abs_err > UNLOCK_WIN;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q      <= '0;
      seed_q    <= '0;
      integ_q   <= '0;
      prop_q    <= '0;
      good_q    <= '0;
      bad_q     <= '0;
      aligned_q <= 1'b0;
      tick_o    <= 1'b0;
      locked_o  <= 1'b0;
      lost_o    <= 1'b0;
    end else begin
      tick_o <= 1'b0;
      lost_o <= 1'b0;
      if (load_i) begin
        seed_q    <= seed_i;
        integ_q   <= '0;
        prop_q    <= '0;
        ph_q      <= '0;
        good_q    <= '0;
        bad_q     <= '0;
        aligned_q <= 1'b0;
        locked_o  <= 1'b0;
      end else if (!en_i) begin
        good_q    <= '0;
        bad_q     <= '0;
        aligned_q <= 1'b0;
        locked_o  <= 1'b0;
      end else if (edge_i && !aligned_q) begin
        ph_q      <= inc_u;  // edge counts as the first step of the bit
        aligned_q <= 1'b1;
      end else begin
        ph_q   <= sum[ACC_W-1:0];
        tick_o <= sum[ACC_W];
        if (edge_i) begin
          prop_q  <= -(err_s >>> KP_SH);
          integ_q <= integ_q - (err_s >>> KI_SH);
          if (err_in) begin
            if (good_q != LW'(LOCK_EDGES)) good_q <= good_q + 1'b1;
            if (good_q >= LW'(LOCK_EDGES - 1)) locked_o <= 1'b1;
          end else begin
            good_q <= '0;
          end
          if (err_out) begin
            if (bad_q != UW'(UNLOCK_EDGES)) bad_q <= bad_q + 1'b1;
            if (bad_q >= UW'(UNLOCK_EDGES - 1)) begin
              lost_o   <= 1'b1;
              locked_o <= 1'b0;
            end
          end else begin
            bad_q <= '0;
          end
        end
      end
    end
  end

  AST_TICK_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o); // R5
  AST_LOCK_IN_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o |-> en_i); // R8
  AST_LOST_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lost_o |-> !locked_o); // R7
  AST_LOCK_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> $past(edge_i)); // R6
  AST_INC_POS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && aligned_q) |-> !inc_s[SW-1]); // R4
endmodule

// File: rtl/rate_acq_top.sv
module rate_acq_top
  import rate_acq_pkg::*;
#(
  parameter int CNT_W        = 12,
  parameter int ACC_W        = 24,
  parameter int EDG_W        = 8,
  parameter int KP_SH        = 10,
  parameter int KI_SH        = 14,
  parameter int LOCK_SH      = 3,
  parameter int UNLOCK_SH    = 2,
  parameter int LOCK_EDGES   = 8,
  parameter int UNLOCK_EDGES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             line_i,
  input  logic [EDG_W-1:0] meas_edges_i,
  output logic             tick_o,
  output logic             locked_o,
  output logic             period_vld_o,
  output logic [CNT_W-1:0] period_o
);
  acq_st_e          st_q;
  logic             line_q, edge_w;
  logic             meas_done, div_done, lost, div_start, trk_load;
  logic [ACC_W-1:0] seed;

  assign edge_w    = line_i ^ line_q;
  assign div_start = (st_q == ST_MEAS) && meas_done;
  assign trk_load  = (st_q == ST_DIV) && div_done;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q       <= 1'b0;
      st_q         <= ST_MEAS;
      period_vld_o <= 1'b0;
    end else begin
      line_q <= line_i;
      unique case (st_q)
        ST_MEAS: if (meas_done) begin
          st_q         <= ST_DIV;
          period_vld_o <= 1'b1;
        end
        ST_DIV: if (div_done) st_q <= ST_TRACK;
        ST_TRACK: if (lost) begin
          st_q         <= ST_MEAS;
          period_vld_o <= 1'b0;
        end
        default: st_q <= ST_MEAS;
      endcase
    end
  end

  rate_acq_meas #(.CNT_W(CNT_W), .EDG_W(EDG_W)) u_meas (
    .clk_i, .rst_ni,
    .en_i        (st_q == ST_MEAS),
    .edge_i      (edge_w),
    .meas_edges_i,
    .done_o      (meas_done),
    .period_o    (period_o)
  );

  rate_acq_div #(.ACC_W(ACC_W), .CNT_W(CNT_W)) u_div (
    .clk_i, .rst_ni,
    .start_i   (div_start),
    .divisor_i (period_o),
    .done_o    (div_done),
    .quot_o    (seed)
  );

  rate_acq_track #(
    .ACC_W(ACC_W), .KP_SH(KP_SH), .KI_SH(KI_SH), .LOCK_SH(LOCK_SH),
    .UNLOCK_SH(UNLOCK_SH), .LOCK_EDGES(LOCK_EDGES), .UNLOCK_EDGES(UNLOCK_EDGES)
  ) u_track (
    .clk_i, .rst_ni,
    .en_i     (st_q == ST_TRACK),
    .load_i   (trk_load),
    .seed_i   (seed),
    .edge_i   (edge_w),
    .tick_o   (tick_o),
    .locked_o (locked_o),
    .lost_o   (lost)
  );

  AST_PERIOD_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_vld_o |-> (period_o >= CNT_W'(2))); // R3
  AST_PERIOD_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (period_vld_o && $past(period_vld_o)) |-> $stable(period_o)); // R2
  AST_LOCK_VLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o |-> period_vld_o); // R8
endmodule

// File: tb/rate_acq_top_tb.sv
module rate_acq_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYC     = 150000;
  localparam int CNT_W      = 12;
  localparam int EDG_W      = 8;

  typedef struct packed {
    int unsigned per;
    int unsigned edges;
    int unsigned exp_per;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{per: 10,  edges: 4, exp_per: 10},
    '{per: 23,  edges: 8, exp_per: 23},
    '{per: 64,  edges: 2, exp_per: 64},
    '{per: 100, edges: 6, exp_per: 100}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             line = 1'b0;
  logic [EDG_W-1:0] meas_edges = 8'd4;
  logic             tick, locked, period_vld;
  logic [CNT_W-1:0] period;

  int  n_chk = 0, n_fail = 0;
  bit  finished = 1'b0;
  bit  cnt_on = 1'b0, mon_on = 1'b0;
  int  tick_n = 0, dbl_n = 0;
  bit  tick_prev = 1'b0, saw_unl = 1'b0, saw_nv = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rate_acq_top u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .line_i       (line),
    .meas_edges_i (meas_edges),
    .tick_o       (tick),
    .locked_o     (locked),
    .period_vld_o (period_vld),
    .period_o     (period)
  );

  always @(negedge clk) begin
    if (cnt_on) begin
      if (tick) tick_n++;
      if (tick && tick_prev) dbl_n++;
    end
    tick_prev = tick;
    if (mon_on && !locked) saw_unl = 1'b1;
    if (mon_on && !period_vld) saw_nv = 1'b1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    line  = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic gap(input int p);
    repeat (p) @(negedge clk);
    line = ~line;
  endtask

  task automatic run_edges(input int p, input int n);
    for (int i = 0; i < n; i++) gap(p);
  endtask

  initial begin
    repeat (WD_CYC) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    do_reset();
    chk(tick == 1'b0, "R1 tick", int'(tick), 0);
    chk(locked == 1'b0, "R1 locked", int'(locked), 0);
    chk(period_vld == 1'b0, "R1 period_vld", int'(period_vld), 0);
    chk(period == '0, "R1 period", int'(period), 0);

    // vector table: acquisition, lock, tick rate over a wide range
    foreach (VECS[v]) begin
      meas_edges = EDG_W'(VECS[v].edges);
      do_reset();
      run_edges(int'(VECS[v].per), 40);
      chk(period == CNT_W'(VECS[v].exp_per), "R2/R10 period", int'(period), int'(VECS[v].exp_per));
      chk(period_vld, "R2 period_vld", int'(period_vld), 1);
      chk(locked, "R6/R10 lock within 40 edges", int'(locked), 1);
      tick_n = 0;
      dbl_n  = 0;
      cnt_on = 1'b1;
      run_edges(int'(VECS[v].per), 32);
      cnt_on = 1'b0;
      chk(tick_n >= 31 && tick_n <= 33, "R4 ticks per 32 bits", tick_n, 32);
      chk(dbl_n == 0, "R5 back-to-back ticks", dbl_n, 0);
      chk(locked, "R9 lock held", int'(locked), 1);
      chk(!locked || period_vld, "R8 lock needs period", int'(period_vld), 1);
    end

    // R2: minimum interval wins
    meas_edges = 8'd4;
    do_reset();
    gap(30);
    gap(60); gap(45); gap(60); gap(60);
    repeat (40) @(negedge clk);
    chk(period == CNT_W'(45), "R2 minimum interval", int'(period), 45);
    chk(locked == 1'b0, "R8 no lock without edges", int'(locked), 0);

    // R3: one-clock glitch clamps to 2
    meas_edges = 8'd3;
    do_reset();
    gap(30);
    gap(30); gap(1); gap(30);
    repeat (40) @(negedge clk);
    chk(period == CNT_W'(2), "R3 clamp", int'(period), 2);
    chk(period_vld, "R3 period_vld", int'(period_vld), 1);

    // R7: half-bit phase jump drops lock, then re-acquire
    meas_edges = 8'd4;
    do_reset();
    run_edges(40, 40);
    chk(locked, "R7 locked before jump", int'(locked), 1);
    saw_unl = 1'b0;
    saw_nv  = 1'b0;
    mon_on  = 1'b1;
    gap(60);
    run_edges(40, 8);
    mon_on  = 1'b0;
    chk(saw_unl, "R7 lock dropped", int'(saw_unl), 1);
    chk(saw_nv, "R7 remeasure", int'(saw_nv), 1);
    run_edges(40, 40);
    chk(locked, "R7 relocked", int'(locked), 1);
    chk(period == CNT_W'(40), "R7 period after relock", int'(period), 40);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule